// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block watches every bus cycle that the processor and the other bus masters issue, and it raises a debug break request when a cycle meets the conditions programmed into either of its two independent channels. Each channel holds five programmed values: a compare address and its ignore mask, a compare data word and its ignore mask, and a cycle-condition word. The condition word chooses the bus (local or system), the access kind (instruction fetch or data access), the direction (read or write) and the set of system-bus masters to watch.

A match sets a sticky flag that records the channel and the bus on which the match happened. Software reads these flags through a small register port and clears them by writing zero. A single break request line goes to the processor. When both channels match on the same cycle, the line still pulses once, and the flags of both channels are set.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, every register reads back as zero, both channels are disabled, and `brk_req` is low.
- R2: An address bit is compared only where the channel's address-mask bit is 0; bits with a mask of 1 never prevent a match.
- R3: A data bit is compared only where the channel's data-mask bit is 0; bits with a mask of 1 never prevent a match.
- R4: The condition word has three two-bit selectors: bits 1:0 pick the bus (01 local, 10 system, 11 both), bits 3:2 the kind (01 fetch, 10 data, 11 both), bits 5:4 the direction (01 read, 10 write, 11 both). A selector left at 00 keeps that channel from ever matching.
- R5: Condition bits 8:6 select the watched masters for system-bus cycles (bit 6 processor, bit 7 DMA controller, bit 8 transfer controller; `bus_master` codes 0, 1, 2; code 3 never matches a system-bus cycle). Local-bus cycles ignore the master select.
- R6: A system-bus cycle counts as a fetch only if `bus_fetch` is high and the master is the processor; every cycle of the DMA or transfer controller counts as a data access.
- R7: A match sets the channel's local flag or system flag, according to `bus_sys`. Hardware never clears a flag. Status bits: 0 = A local, 1 = A system, 2 = B local, 3 = B system.
- R8: Writing a 0 to a status bit clears it; writing a 1 leaves it unchanged.
- R9: When both channels match in one cycle, `brk_req` is high for exactly one cycle, and the flags of both channels are set.
- R10: `brk_req` goes high for one cycle on the clock edge after a matching cycle that has `bus_valid` high. No match occurs while `bus_valid` is low.
- R11: Register map on `reg_addr`: channel A at 0..4 and channel B at 8..12 (address, address mask, data, data mask, condition), status at 16. The condition reads back 9 bits. Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle present this clock |
| bus_addr | input | ADDR_W | Cycle address |
| bus_data | input | DATA_W | Cycle data |
| bus_sys | input | 1 | 1 = system bus, 0 = local bus |
| bus_fetch | input | 1 | Cycle marked as an instruction fetch |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_master | input | 2 | Issuing master: 0 processor, 1 DMA, 2 transfer controller |
| brk_req | output | 1 | One-cycle break request |

## Verification
Address and data compares are driven with values that differ from the programmed word only in masked bits, and then with values that differ in one unmasked bit. This shows that each mask acts bit by bit and only inside its own field. Each selector is swept over a matching value and a conflicting value, and one group is left at 00 to show that the channel is disabled. System-bus cycles from each master, marked with and without the fetch flag, separate the master filter from the fetch classification. Simultaneous matches on both channels, repeated matches and writes of ones and zeros to the status register show the single pulse, the per-bus flag choice, and the rule that only software clears a flag.

// File: rtl/bkpt_pkg.sv
// Shared constants and types for the bus breakpoint comparator.
// Assumes two channels; register map slots derive from that count.
package bkpt_pkg;
    localparam int NUM_CH   = 2;
    localparam int COND_W   = 9;
    localparam int FLAG_W   = 2 * NUM_CH;
    localparam int RADDR_W  = 5;

    // field index within a channel's register slot
    localparam logic [2:0] F_ADDR  = 3'd0;
    localparam logic [2:0] F_AMASK = 3'd1;
    localparam logic [2:0] F_DATA  = 3'd2;
    localparam logic [2:0] F_DMASK = 3'd3;
    localparam logic [2:0] F_COND  = 3'd4;

    localparam logic [RADDR_W-1:0] STATUS_ADDR = RADDR_W'(NUM_CH * 8);

    localparam logic [1:0] MST_CPU = 2'd0;

    // condition word: masters, direction, kind, bus (LSB)
    typedef struct packed {
        logic [2:0] mst;
        logic [1:0] dir;
        logic [1:0] kind;
        logic [1:0] bus;
    } cond_t;
endpackage

// File: rtl/bkpt_regs.sv
// Register file: per-channel compare values, condition words and the
// sticky status flags. Assumes ADDR_W and DATA_W do not exceed 32.
// Hardware sets flags; software clears them by writing zero.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [RADDR_W-1:0]               reg_addr,
    input  logic [31:0]                      reg_wdata,
    output logic [31:0]                      reg_rdata,
    input  logic [FLAG_W-1:0]                set_flags,
    output logic [NUM_CH-1:0][ADDR_W-1:0]    addr_q,
    output logic [NUM_CH-1:0][ADDR_W-1:0]    amask_q,
    output logic [NUM_CH-1:0][DATA_W-1:0]    data_q,
    output logic [NUM_CH-1:0][DATA_W-1:0]    dmask_q,
    output logic [NUM_CH-1:0][COND_W-1:0]    cond_q,
    output logic [FLAG_W-1:0]                status_q
);
    logic [1:0] slot;
    logic [2:0] field;
    logic       status_wr;

    assign slot      = reg_addr[4:3];
    assign field     = reg_addr[2:0];
    assign status_wr = reg_we && (reg_addr == STATUS_ADDR);

    // channel register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            amask_q <= '0;
            data_q  <= '0;
            dmask_q <= '0;
            cond_q  <= '0;
        end else if (reg_we) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (slot == 2'(c)) begin
                    case (field)
                        F_ADDR:  addr_q[c]  <= reg_wdata[ADDR_W-1:0];
                        F_AMASK: amask_q[c] <= reg_wdata[ADDR_W-1:0];
                        F_DATA:  data_q[c]  <= reg_wdata[DATA_W-1:0];
                        F_DMASK: dmask_q[c] <= reg_wdata[DATA_W-1:0];
                        F_COND:  cond_q[c]  <= reg_wdata[COND_W-1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // sticky flags: write-zero clears, hardware set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_wr ? (status_q & reg_wdata[FLAG_W-1:0]) : status_q)
                        | set_flags;
    end

    // read-back multiplexer
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == STATUS_ADDR) begin
            reg_rdata = 32'(status_q);
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (slot == 2'(c)) begin
                    case (field)
                        F_ADDR:  reg_rdata = 32'(addr_q[c]);
                        F_AMASK: reg_rdata = 32'(amask_q[c]);
                        F_DATA:  reg_rdata = 32'(data_q[c]);
                        F_DMASK: reg_rdata = 32'(dmask_q[c]);
                        F_COND:  reg_rdata = 32'(cond_q[c]);
                        default: reg_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/bkpt_match.sv
// One channel's comparator: masked address/data compare plus the
// condition selectors. Purely combinational; assumes bus_master code 3
// is never a valid system-bus master.
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_sys,
    input  logic              bus_fetch,
    input  logic              bus_write,
    input  logic [1:0]        bus_master,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic [ADDR_W-1:0] cmp_amask,
    input  logic [DATA_W-1:0] cmp_data,
    input  logic [DATA_W-1:0] cmp_dmask,
    input  logic [COND_W-1:0] cond_raw,
    output logic              hit_local,
    output logic              hit_sys
);
    cond_t cond;
    logic  eff_fetch, bus_ok, kind_ok, dir_ok, mst_ok, addr_ok, data_ok, hit;

    assign cond = cond_t'(cond_raw);

    // system-bus fetch counts only when the processor issues it
    assign eff_fetch = bus_fetch && (!bus_sys || bus_master == MST_CPU);

    // selector evaluation
    always_comb begin
        bus_ok  = bus_sys   ? cond.bus[1]  : cond.bus[0];
        kind_ok = eff_fetch ? cond.kind[0] : cond.kind[1];
        dir_ok  = bus_write ? cond.dir[1]  : cond.dir[0];
        case (bus_master)
            2'd0:    mst_ok = cond.mst[0];
            2'd1:    mst_ok = cond.mst[1];
            2'd2:    mst_ok = cond.mst[2];
            default: mst_ok = 1'b0;
        endcase
        if (!bus_sys) mst_ok = 1'b1;
    end

    assign addr_ok = ((bus_addr ^ cmp_addr) & ~cmp_amask) == '0;
    assign data_ok = ((bus_data ^ cmp_data) & ~cmp_dmask) == '0;
    assign hit     = bus_valid && bus_ok && kind_ok && dir_ok && mst_ok
                     && addr_ok && data_ok;

    assign hit_local = hit && !bus_sys;
    assign hit_sys   = hit &&  bus_sys;
endmodule

// File: rtl/bkpt_unit.sv
// Top of the two-channel breakpoint comparator. Channels are generated
// from NUM_CH; any channel hit yields one registered break pulse.
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               bus_valid,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               bus_sys,
    input  logic               bus_fetch,
    input  logic               bus_write,
    input  logic [1:0]         bus_master,
    output logic               brk_req
);
    logic [NUM_CH-1:0][ADDR_W-1:0] addr_q, amask_q;
    logic [NUM_CH-1:0][DATA_W-1:0] data_q, dmask_q;
    logic [NUM_CH-1:0][COND_W-1:0] cond_q;
    logic [FLAG_W-1:0]             status_q;
    logic [FLAG_W-1:0]             set_flags;
    logic [NUM_CH-1:0]             hit_vec;

    bkpt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_flags(set_flags),
        .addr_q(addr_q), .amask_q(amask_q), .data_q(data_q),
        .dmask_q(dmask_q), .cond_q(cond_q), .status_q(status_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bkpt_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
            .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
            .bus_sys(bus_sys), .bus_fetch(bus_fetch), .bus_write(bus_write),
            .bus_master(bus_master),
            .cmp_addr(addr_q[c]), .cmp_amask(amask_q[c]),
            .cmp_data(data_q[c]), .cmp_dmask(dmask_q[c]),
            .cond_raw(cond_q[c]),
            .hit_local(set_flags[2*c]), .hit_sys(set_flags[2*c+1])
        );
        assign hit_vec[c] = set_flags[2*c] | set_flags[2*c+1];
    end

    // one merged break pulse per matching cycle
    always_ff @(posedge clk) begin
        if (!rst_n) brk_req <= 1'b0;
        else        brk_req <= |hit_vec;
    end
endmodule

// File: rtl/bkpt_unit_chk.sv
// Checker for bkpt_unit: timing of the break pulse, flag stickiness,
// write-one-no-effect and disabled-channel silence. Bound below.
module bkpt_unit_chk
    import bkpt_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_valid,
    input logic                          brk_req,
    input logic                          reg_we,
    input logic [4:0]                    reg_addr,
    input logic [31:0]                   reg_wdata,
    input logic [FLAG_W-1:0]             status_q,
    input logic [NUM_CH-1:0]             hit_vec,
    input logic [NUM_CH-1:0][COND_W-1:0] cond_q
);
    logic status_wr;
    assign status_wr = reg_we && (reg_addr == STATUS_ADDR);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !brk_req);

    assert_pulse_after_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid));

    assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (status_q != '0));

    assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(status_wr) |-> ((status_q & $past(status_q)) == $past(status_q)));

    assert_write_one_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_wr && !bus_valid) |-> (status_q == ($past(status_q) & $past(reg_wdata[FLAG_W-1:0]))));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[c] |-> (cond_q[c][1:0] != 2'b00 && cond_q[c][3:2] != 2'b00
                            && cond_q[c][5:4] != 2'b00));
    end
endmodule

bind bkpt_unit bkpt_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .brk_req(brk_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_q(status_q), .hit_vec(hit_vec), .cond_q(cond_q)
);

// File: tb/bkpt_unit_test.sv
// Directed bench for bkpt_unit: one task per scenario, each self-checking.
module bkpt_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        bus_sys = 1'b0;
    logic        bus_fetch = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_master = 2'd0;
    logic        brk_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bkpt_unit uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cnd(input logic [1:0] b, input logic [1:0] k,
                                        input logic [1:0] dr, input logic [2:0] m);
        return {23'd0, m, dr, k, b};
    endfunction

    // one bus cycle; checks pulse after the edge and its drop one cycle later
    task automatic cyc(input string req, input logic v, input logic [31:0] a,
                       input logic [31:0] d, input logic s, input logic f,
                       input logic w, input logic [1:0] m, input logic exp);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d;
        bus_sys = s; bus_fetch = f; bus_write = w; bus_master = m;
        @(negedge clk);
        bus_valid = 1'b0;
        chk(req, 32'(brk_req), 32'(exp));
        @(negedge clk);
        chk({req, " pulse width"}, 32'(brk_req), 32'd0);
    endtask

    task automatic setup_ch(input int c, input logic [31:0] a, input logic [31:0] am,
                            input logic [31:0] d, input logic [31:0] dm, input logic [31:0] cd);
        logic [4:0] base;
        base = 5'(c * 8);
        wr(base + 5'd0, a);
        wr(base + 5'd1, am);
        wr(base + 5'd2, d);
        wr(base + 5'd3, dm);
        wr(base + 5'd4, cd);
    endtask

    task automatic clean();
        setup_ch(0, 0, 0, 0, 0, 0);
        setup_ch(1, 0, 0, 0, 0, 0);
        wr(5'd16, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 brk_req after reset", 32'(brk_req), 32'd0);
        for (int i = 0; i < 17; i++) begin
            rd(5'(i), v);
            chk("R1 register zero", v, 32'd0);
        end
        cyc("R1 disabled after reset", 1, 32'd0, 32'd0, 0, 0, 0, 2'd0, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        setup_ch(0, 32'h1111_0001, 32'h2222_0002, 32'h3333_0003, 32'h4444_0004, 32'hFFFF_FFFF);
        setup_ch(1, 32'h5555_0005, 32'h6666_0006, 32'h7777_0007, 32'h8888_0008, 32'h0000_0123);
        rd(5'd0, v);  chk("R11 A addr", v, 32'h1111_0001);
        rd(5'd3, v);  chk("R11 A dmask", v, 32'h4444_0004);
        rd(5'd4, v);  chk("R11 A cond 9 bits", v, 32'h0000_01FF);
        rd(5'd9, v);  chk("R11 B amask", v, 32'h6666_0006);
        rd(5'd10, v); chk("R11 B data", v, 32'h7777_0007);
        rd(5'd12, v); chk("R11 B cond", v, 32'h0000_0123);
        rd(5'd6, v);  chk("R11 unmapped", v, 32'd0);
        clean();
    endtask

    task automatic t_addr_mask();
        setup_ch(0, 32'h1000_0040, 32'h0000_000F, 0, 32'hFFFF_FFFF, cnd(3, 3, 3, 3'b111));
        cyc("R2 masked bits differ", 1, 32'h1000_004A, 32'hDEAD_BEEF, 0, 0, 0, 2'd0, 1);
        cyc("R2 unmasked bit differs", 1, 32'h1000_0050, 32'hDEAD_BEEF, 0, 0, 0, 2'd0, 0);
        cyc("R2 high bit differs", 1, 32'h9000_0040, 32'h0, 0, 0, 0, 2'd0, 0);
        clean();
    endtask

    task automatic t_data_mask();
        setup_ch(1, 0, 32'hFFFF_FFFF, 32'hA5A5_0000, 32'h0000_FFFF, cnd(3, 3, 3, 3'b111));
        cyc("R3 masked data differ", 1, 32'h1234, 32'hA5A5_1234, 0, 0, 1, 2'd0, 1);
        cyc("R3 unmasked data differ", 1, 32'h1234, 32'hA4A5_0000, 0, 0, 1, 2'd0, 0);
        clean();
    endtask

    task automatic t_groups();
        setup_ch(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, cnd(2'b01, 2'b01, 2'b01, 3'b111));
        cyc("R4 local fetch read", 1, 0, 0, 0, 1, 0, 2'd0, 1);
        cyc("R4 system bus rejected", 1, 0, 0, 1, 1, 0, 2'd0, 0);
        cyc("R4 write rejected", 1, 0, 0, 0, 1, 1, 2'd0, 0);
        cyc("R4 data access rejected", 1, 0, 0, 0, 0, 0, 2'd0, 0);
        wr(5'd4, cnd(2'b11, 2'b11, 2'b00, 3'b111));
        cyc("R4 zero dir group disables", 1, 0, 0, 0, 1, 0, 2'd0, 0);
        wr(5'd4, cnd(2'b00, 2'b11, 2'b11, 3'b111));
        cyc("R4 zero bus group disables", 1, 0, 0, 1, 0, 1, 2'd1, 0);
        clean();
    endtask

    task automatic t_master();
        setup_ch(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, cnd(2'b11, 2'b10, 2'b11, 3'b010));
        cyc("R5 cpu not selected", 1, 0, 0, 1, 0, 0, 2'd0, 0);
        cyc("R5 dma selected", 1, 0, 0, 1, 0, 1, 2'd1, 1);
        cyc("R5 transfer ctrl not selected", 1, 0, 0, 1, 0, 0, 2'd2, 0);
        cyc("R5 local ignores master select", 1, 0, 0, 0, 0, 0, 2'd0, 1);
        clean();
    endtask

    task automatic t_fetch_class();
        setup_ch(1, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, cnd(2'b10, 2'b01, 2'b11, 3'b111));
        cyc("R6 dma fetch is not fetch", 1, 0, 0, 1, 1, 0, 2'd1, 0);
        cyc("R6 transfer fetch is not fetch", 1, 0, 0, 1, 1, 0, 2'd2, 0);
        cyc("R6 cpu system fetch", 1, 0, 0, 1, 1, 0, 2'd0, 1);
        wr(5'd12, cnd(2'b10, 2'b10, 2'b11, 3'b111));
        cyc("R6 dma fetch-marked counts as data", 1, 0, 0, 1, 1, 0, 2'd1, 1);
        clean();
    endtask

    task automatic t_flags();
        logic [31:0] v;
        setup_ch(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, cnd(3, 3, 3, 3'b111));
        cyc("R7 local match", 1, 0, 0, 0, 0, 0, 2'd0, 1);
        rd(5'd16, v); chk("R7 A local flag", v, 32'h1);
        repeat (3) @(negedge clk);
        rd(5'd16, v); chk("R7 flag sticky while idle", v, 32'h1);
        cyc("R7 system match", 1, 0, 0, 1, 0, 0, 2'd0, 1);
        rd(5'd16, v); chk("R7 A system flag added", v, 32'h3);
        wr(5'd16, 32'hF);
        rd(5'd16, v); chk("R8 write ones no effect", v, 32'h3);
        wr(5'd16, 32'hE);
        rd(5'd16, v); chk("R8 write zero clears bit0", v, 32'h2);
        clean();
        rd(5'd16, v); chk("R8 all cleared", v, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] v;
        setup_ch(0, 32'h40, 0, 0, 32'hFFFF_FFFF, cnd(3, 3, 3, 3'b111));
        setup_ch(1, 32'h40, 0, 0, 32'hFFFF_FFFF, cnd(2'b10, 3, 3, 3'b001));
        cyc("R9 both match one pulse", 1, 32'h40, 0, 1, 0, 0, 2'd0, 1);
        rd(5'd16, v); chk("R9 both system flags", v, 32'hA);
        cyc("R9 only A on local", 1, 32'h40, 0, 0, 0, 0, 2'd0, 1);
        rd(5'd16, v); chk("R9 A local added", v, 32'hB);
        clean();
    endtask

    task automatic t_timing();
        setup_ch(0, 32'h80, 0, 0, 32'hFFFF_FFFF, cnd(3, 3, 3, 3'b111));
        cyc("R10 no valid no match", 0, 32'h80, 0, 0, 0, 0, 2'd0, 0);
        @(negedge clk);
        bus_valid = 1; bus_addr = 32'h80; bus_sys = 0; bus_master = 0;
        #1 chk("R10 no pulse before edge", 32'(brk_req), 32'd0);
        @(negedge clk);
        chk("R10 pulse after edge", 32'(brk_req), 32'd1);
        @(negedge clk);
        bus_valid = 0;
        chk("R10 back-to-back match pulse", 32'(brk_req), 32'd1);
        @(negedge clk);
        chk("R10 pulse ends", 32'(brk_req), 32'd0);
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_addr_mask();
        t_data_mask();
        t_groups();
        t_master();
        t_fetch_class();
        t_flags();
        t_both();
        t_timing();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule